// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler

This block sits between instruction decode and the execution units. It keeps up to eight decoded two-register operations in a small window, in the order the program gave them. Each operation names a destination register, which it also reads, a source register and an execution class. In every cycle the scheduler looks at the window, finds the entries whose registers are not waiting on an unfinished result and whose execution unit is free, and sends up to two of them to execution. The oldest eligible entries go first. A younger entry may leave ahead of an older one that is stalled.

A per-register pending bit marks each result that has been issued but not yet written. It is set when the producing operation issues and cleared when the execution side reports the write-back. The divider is a single non-pipelined unit that stays occupied for several cycles. The multiplier is a single unit. There are two add/sub units.

Decoded operations enter through a valid/ready stream. A transfer takes place on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on window occupancy, never on `in_valid`. The source must hold its operation stable until the transfer. The issue ports have no back-pressure, because the scheduler only issues to units it knows are free. Write-back ports are plain strobes.

Top module: `issue_sched`

## Requirements
- R1: `in_ready` is high exactly when the window holds fewer than DEPTH (8) entries. An operation accepted at an edge can issue from the next cycle on.
- R2: An entry issues only when neither its destination nor its source register is pending. A register becomes pending at the edge that ends its producer's issue cycle. It is released by a write-back strobe for it, and a dependent operation can issue in the cycle after that strobe.
- R3: An entry waits while any older entry still in the window writes a register the entry reads, or reads the register the entry writes.
- R4: An eligible entry issues even when older entries in the window are stalled.
- R5: At most two entries issue per cycle, and the oldest eligible ones are picked. Slot 0 carries the older of the pair, and slot 1 is valid only when slot 0 is valid. Window order is kept as entries leave, so later picks still follow program order.
- R6: Class codes are 0 for add/sub, 1 for multiply and 2 for divide, and code 3 is treated as add/sub. Two add/sub operations may issue together. Two multiplies or two divides never issue in the same cycle.
- R7: After a divide issues in cycle c, no divide issues before cycle c+DIV_LAT (4). A ready divide issues in cycle c+DIV_LAT.
- R8: During and right after reset the window is empty, no register is pending, the divider is free, `in_ready` is high and both issue slots are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Decoded operation offered |
| in_ready | output | 1 | Window can take an operation |
| in_dst | input | RW (4) | Destination register, also read |
| in_src | input | RW (4) | Source register |
| in_cls | input | 2 | Execution class code |
| iss_valid | output | 2 | Issue strobe per slot, bit 0 is the older slot |
| iss_dst | output | 2*RW (8) | Destination per slot, slot k in bits k*RW +: RW |
| iss_src | output | 2*RW (8) | Source per slot |
| iss_cls | output | 4 | Class per slot, slot k in bits 2k +: 2 |
| wb_valid | input | NWB (4) | Write-back strobe per port |
| wb_reg | input | NWB*RW (16) | Register written back per port |

## Verification
Two things can land on the same clock edge. Entries leave the window on issue while a new operation is appended and the survivors slide down. A write-back can also release a register that several waiting entries need at once. The window-full scenario provokes both. Eight additions wait on a withheld result, the window fills, and the result is then released. This frees two slots per cycle while a stalled operation streams in behind them. The check compares the exact issue cycle and slot of every entry with cycles worked out by hand from the requirements, and also checks `in_ready` in the cycles around the release.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;
  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_MUL = 2'd1,
    CLS_DIV = 2'd2,
    CLS_ALT = 2'd3
  } cls_e;

  // a class with a single unit instance cannot take two ops in one cycle
  function automatic logic cls_single(input logic [1:0] c);
    return (c == CLS_MUL) || (c == CLS_DIV);
  endfunction

  function automatic logic cls_pairable(input logic [1:0] a, input logic [1:0] b);
    return !((a == b) && cls_single(a));
  endfunction
endpackage

// File: rtl/sched_scoreboard.sv
`timescale 1ns/1ps
module sched_scoreboard #(
  parameter int NREG = 16,
  parameter int RW   = 4,
  parameter int NWB  = 4,
  parameter int NSET = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSET-1:0]      set_v,
  input  logic [NSET*RW-1:0]   set_r,
  input  logic [NWB-1:0]       clr_v,
  input  logic [NWB*RW-1:0]    clr_r,
  output logic [NREG-1:0]      pend
);
  logic [NREG-1:0] pend_n;

  always_comb begin
    pend_n = pend;
    for (int w = 0; w < NWB; w++) begin
      if (clr_v[w]) pend_n[clr_r[w*RW +: RW]] = 1'b0;
    end
    for (int s = 0; s < NSET; s++) begin
      if (set_v[s]) pend_n[set_r[s*RW +: RW]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_n;
  end
endmodule

// File: rtl/sched_hazard.sv
`timescale 1ns/1ps
module sched_hazard
  import sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NREG  = 16,
  parameter int RW    = 4,
  parameter int CW    = 4
) (
  input  logic [CW-1:0]       occ,
  input  logic [DEPTH*RW-1:0] dst_flat,
  input  logic [DEPTH*RW-1:0] src_flat,
  input  logic [2*DEPTH-1:0]  cls_flat,
  input  logic [NREG-1:0]     pend,
  input  logic                div_free,
  output logic [DEPTH-1:0]    elig
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [RW-1:0] di, si;
    logic [1:0]    ci;
    logic          older_block;

    assign di = dst_flat[i*RW +: RW];
    assign si = src_flat[i*RW +: RW];
    assign ci = cls_flat[2*i +: 2];

    // compare against every older entry still waiting in the window
    always_comb begin
      logic [RW-1:0] dj, sj;
      older_block = 1'b0;
      for (int j = 0; j < i; j++) begin
        dj = dst_flat[j*RW +: RW];
        sj = src_flat[j*RW +: RW];
        if (dj == di || dj == si || sj == di) older_block = 1'b1;
      end
    end

    assign elig[i] = (CW'(i) < occ) && !older_block &&
                     !pend[di] && !pend[si] &&
                     ((ci != CLS_DIV) || div_free);
  end
endmodule

// File: rtl/sched_pick.sv
`timescale 1ns/1ps
module sched_pick
  import sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input  logic [DEPTH-1:0]   elig,
  input  logic [2*DEPTH-1:0] cls_flat,
  output logic               v0,
  output logic [IW-1:0]      idx0,
  output logic               v1,
  output logic [IW-1:0]      idx1
);
  logic [1:0] c0;

  always_comb begin
    v0   = 1'b0;
    idx0 = '0;
    v1   = 1'b0;
    idx1 = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!v0 && elig[i]) begin
        v0   = 1'b1;
        idx0 = IW'(i);
      end
    end
    c0 = cls_flat[2*idx0 +: 2];
    for (int i = 0; i < DEPTH; i++) begin
      if (v0 && !v1 && elig[i] && (i > int'(idx0)) &&
          cls_pairable(cls_flat[2*i +: 2], c0)) begin
        v1   = 1'b1;
        idx1 = IW'(i);
      end
    end
  end
endmodule

// File: rtl/issue_sched.sv
`timescale 1ns/1ps
module issue_sched
  import sched_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int NREG    = 16,
  parameter int NWB     = 4,
  parameter int DIV_LAT = 4,
  localparam int RW     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RW-1:0]     in_dst,
  input  logic [RW-1:0]     in_src,
  input  logic [1:0]        in_cls,
  output logic [1:0]        iss_valid,
  output logic [2*RW-1:0]   iss_dst,
  output logic [2*RW-1:0]   iss_src,
  output logic [3:0]        iss_cls,
  input  logic [NWB-1:0]    wb_valid,
  input  logic [NWB*RW-1:0] wb_reg
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam int DW = $clog2(DIV_LAT) + 1;

  logic [RW-1:0] w_dst [DEPTH];
  logic [RW-1:0] w_src [DEPTH];
  logic [1:0]    w_cls [DEPTH];
  logic [CW-1:0] occ;

  logic [RW-1:0] n_dst [DEPTH];
  logic [RW-1:0] n_src [DEPTH];
  logic [1:0]    n_cls [DEPTH];
  logic [CW-1:0] occ_n;

  logic [DEPTH*RW-1:0] dst_flat, src_flat;
  logic [2*DEPTH-1:0]  cls_flat;

  for (genvar k = 0; k < DEPTH; k++) begin : g_flat
    assign dst_flat[k*RW +: RW] = w_dst[k];
    assign src_flat[k*RW +: RW] = w_src[k];
    assign cls_flat[2*k +: 2]   = w_cls[k];
  end

  logic [NREG-1:0]  pend;
  logic [DW-1:0]    div_cnt;
  logic             div_free;
  logic [DEPTH-1:0] elig;
  logic             v0, v1;
  logic [IW-1:0]    idx0, idx1;
  logic             acc, div_go;
  logic [CW-1:0]    n_rem, base;

  assign div_free = (div_cnt == '0);
  assign in_ready = (occ < CW'(DEPTH));
  assign acc      = in_valid && in_ready;

  sched_hazard #(.DEPTH(DEPTH), .NREG(NREG), .RW(RW), .CW(CW)) u_hazard (
    .occ(occ), .dst_flat(dst_flat), .src_flat(src_flat), .cls_flat(cls_flat),
    .pend(pend), .div_free(div_free), .elig(elig)
  );

  sched_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick (
    .elig(elig), .cls_flat(cls_flat),
    .v0(v0), .idx0(idx0), .v1(v1), .idx1(idx1)
  );

  assign iss_valid = {v1, v0};
  assign iss_dst   = {v1 ? w_dst[idx1] : '0, v0 ? w_dst[idx0] : '0};
  assign iss_src   = {v1 ? w_src[idx1] : '0, v0 ? w_src[idx0] : '0};
  assign iss_cls   = {v1 ? w_cls[idx1] : 2'b00, v0 ? w_cls[idx0] : 2'b00};

  sched_scoreboard #(.NREG(NREG), .RW(RW), .NWB(NWB), .NSET(2)) u_sb (
    .clk(clk), .rst_n(rst_n),
    .set_v(iss_valid), .set_r(iss_dst),
    .clr_v(wb_valid), .clr_r(wb_reg),
    .pend(pend)
  );

  // divider occupancy: a new divide may go once the count is back to zero
  assign div_go = (v0 && w_cls[idx0] == CLS_DIV) || (v1 && w_cls[idx1] == CLS_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 div_cnt <= '0;
    else if (div_go)            div_cnt <= DW'(DIV_LAT - 1);
    else if (div_cnt != '0)     div_cnt <= div_cnt - 1'b1;
  end

  // compaction: survivors slide toward slot 0, new entry lands after them
  assign n_rem = CW'(v0) + CW'(v1);
  assign base  = occ - n_rem;
  assign occ_n = occ - n_rem + CW'(acc);

  always_comb begin
    int s;
    for (int k = 0; k < DEPTH; k++) begin
      s = k;
      if (v0 && s >= int'(idx0)) s = s + 1;
      if (v1 && s >= int'(idx1)) s = s + 1;
      if (acc && CW'(k) == base) begin
        n_dst[k] = in_dst;
        n_src[k] = in_src;
        n_cls[k] = in_cls;
      end else if (s < DEPTH) begin
        n_dst[k] = w_dst[IW'(s)];
        n_src[k] = w_src[IW'(s)];
        n_cls[k] = w_cls[IW'(s)];
      end else begin
        n_dst[k] = '0;
        n_src[k] = '0;
        n_cls[k] = 2'b00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        w_dst[k] <= '0;
        w_src[k] <= '0;
        w_cls[k] <= 2'b00;
      end
    end else begin
      occ <= occ_n;
      for (int k = 0; k < DEPTH; k++) begin
        w_dst[k] <= n_dst[k];
        w_src[k] <= n_src[k];
        w_cls[k] <= n_cls[k];
      end
    end
  end
endmodule

// File: rtl/sched_chk.sv
`timescale 1ns/1ps
module sched_chk #(
  parameter int DEPTH   = 8,
  parameter int NREG    = 16,
  parameter int NWB     = 4,
  parameter int DIV_LAT = 4,
  parameter int RW      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        iss_valid,
  input logic [2*RW-1:0]   iss_dst,
  input logic [2*RW-1:0]   iss_src,
  input logic [3:0]        iss_cls,
  input logic [NWB-1:0]    wb_valid,
  input logic [NWB*RW-1:0] wb_reg
);
  int              m_occ;
  int              since_div;
  logic [NREG-1:0] m_pend, m_pend_n;
  logic            div_now;
  logic [RW-1:0]   d0, s0, d1, s1;

  assign d0 = iss_dst[RW-1:0];
  assign d1 = iss_dst[2*RW-1:RW];
  assign s0 = iss_src[RW-1:0];
  assign s1 = iss_src[2*RW-1:RW];
  assign div_now = (iss_valid[0] && iss_cls[1:0] == 2'd2) ||
                   (iss_valid[1] && iss_cls[3:2] == 2'd2);

  always_comb begin
    m_pend_n = m_pend;
    for (int w = 0; w < NWB; w++)
      if (wb_valid[w]) m_pend_n[wb_reg[w*RW +: RW]] = 1'b0;
    if (iss_valid[0]) m_pend_n[d0] = 1'b1;
    if (iss_valid[1]) m_pend_n[d1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_occ     <= 0;
      m_pend    <= '0;
      since_div <= DIV_LAT;
    end else begin
      m_occ  <= m_occ + int'(in_valid && in_ready) - int'(iss_valid[0]) - int'(iss_valid[1]);
      m_pend <= m_pend_n;
      if (div_now)                since_div <= 1;
      else if (since_div < DIV_LAT) since_div <= since_div + 1;
    end
  end

  assert_ready_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (m_occ < DEPTH));

  assert_slot0_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[0] |-> (!m_pend[d0] && !m_pend[s0]));

  assert_slot1_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[1] |-> (!m_pend[d1] && !m_pend[s1]));

  assert_pair_indep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (&iss_valid) |-> (d1 != d0 && s1 != d0 && d1 != s0));

  assert_slot_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[1] |-> iss_valid[0]);

  assert_unit_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&iss_valid) |-> !(iss_cls[1:0] == iss_cls[3:2] &&
                       (iss_cls[1:0] == 2'd1 || iss_cls[1:0] == 2'd2)));

  assert_div_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_now |-> (since_div >= DIV_LAT));
endmodule

bind issue_sched sched_chk #(
  .DEPTH(DEPTH), .NREG(NREG), .NWB(NWB), .DIV_LAT(DIV_LAT), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_src(iss_src),
  .iss_cls(iss_cls), .wb_valid(wb_valid), .wb_reg(wb_reg)
);

// File: tb/issue_sched_tb_top.sv
`timescale 1ns/1ps
module issue_sched_tb_top;
  localparam int RW      = 4;
  localparam int NREG    = 16;
  localparam int NWB     = 4;
  localparam int DIV_LAT = 4;

  // {class[17:16], dst[15:12], src[11:8], expected issue cycle[7:0]}
  localparam logic [17:0] TBL [10] = '{
    {2'd2, 4'd2,  4'd1,  8'd1},
    {2'd0, 4'd3,  4'd2,  8'd6},
    {2'd0, 4'd8,  4'd7,  8'd3},
    {2'd1, 4'd4,  4'd3,  8'd8},
    {2'd0, 4'd10, 4'd9,  8'd5},
    {2'd0, 4'd12, 4'd11, 8'd6},
    {2'd0, 4'd14, 4'd13, 8'd7},
    {2'd0, 4'd5,  4'd4,  8'd10},
    {2'd2, 4'd6,  4'd7,  8'd9},
    {2'd1, 4'd9,  4'd15, 8'd10}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [RW-1:0] in_dst = '0, in_src = '0;
  logic [1:0] in_cls = '0;
  logic [1:0] iss_valid;
  logic [2*RW-1:0] iss_dst, iss_src;
  logic [3:0] iss_cls;
  logic [NWB-1:0] wb_valid = '0;
  logic [NWB*RW-1:0] wb_reg = '0;

  always #2.5 clk = ~clk;

  issue_sched #(.DEPTH(8), .NREG(NREG), .NWB(NWB), .DIV_LAT(DIV_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst(in_dst), .in_src(in_src), .in_cls(in_cls),
    .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_src(iss_src), .iss_cls(iss_cls),
    .wb_valid(wb_valid), .wb_reg(wb_reg)
  );

  logic [RW-1:0] p_dst [16];
  logic [RW-1:0] p_src [16];
  logic [1:0]    p_cls [16];
  int p_n = 0;
  int fi, cyc;
  bit feeding = 0;
  int iss_cyc [NREG];
  int iss_slot [NREG];
  int due [NREG];
  bit hold [NREG];
  int n_iss = 0;
  int n_chk = 0;
  int n_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 0;
      fi  <= 0;
    end else begin
      cyc <= cyc + 1;
      if (in_valid && in_ready) fi <= fi + 1;
    end
  end

  // execution-side model, issue monitor and operation feeder
  always @(negedge clk) begin
    int slot;
    int d;
    slot = 0;
    wb_valid = '0;
    wb_reg   = '0;
    for (int r = 0; r < NREG; r++) begin
      if (!hold[r] && due[r] == cyc && slot < NWB) begin
        wb_valid[slot] = 1'b1;
        wb_reg[slot*RW +: RW] = RW'(r);
        slot = slot + 1;
        due[r] = -1;
      end
    end
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        if (iss_valid[k]) begin
          d = int'(iss_dst[k*RW +: RW]);
          iss_cyc[d]  = cyc;
          iss_slot[d] = k;
          n_iss = n_iss + 1;
          due[d] = cyc + ((iss_cls[2*k +: 2] == 2'd2) ? DIV_LAT : 1);
        end
      end
    end
    if (feeding && fi < p_n) begin
      in_valid = 1'b1;
      in_dst   = p_dst[fi];
      in_src   = p_src[fi];
      in_cls   = p_cls[fi];
    end else begin
      in_valid = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    feeding = 0;
    n_iss = 0;
    for (int r = 0; r < NREG; r++) begin
      due[r] = -1;
      hold[r] = 0;
      iss_cyc[r] = -1;
      iss_slot[r] = -1;
    end
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic go();
    feeding = 1;
    rst_n = 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic put(input int i, input int c, input int d, input int s);
    p_cls[i] = 2'(c);
    p_dst[i] = RW'(d);
    p_src[i] = RW'(s);
  endtask

  initial begin
    #(5.0 * 100000);
    n_err++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    // R8: state while reset is held and right after release
    do_reset();
    chk(iss_valid == 2'b00, "R8 idle in reset", int'(iss_valid), 0);
    chk(in_ready == 1'b1, "R8 ready in reset", int'(in_ready), 1);

    // table walk: mixed program, exact issue cycles (R2 R3 R4 R6 R7)
    p_n = 10;
    for (int i = 0; i < 10; i++)
      put(i, int'(TBL[i][17:16]), int'(TBL[i][15:12]), int'(TBL[i][11:8]));
    go();
    chk(iss_valid == 2'b00 && in_ready, "R8 empty after release", int'(iss_valid), 0);
    wait_cyc(16);
    for (int i = 0; i < 10; i++) begin
      chk(iss_cyc[TBL[i][15:12]] == int'(TBL[i][7:0]), "R2/R3/R4 table issue cycle",
          iss_cyc[TBL[i][15:12]], int'(TBL[i][7:0]));
    end
    // R6: two add/sub in one cycle, older in slot 0
    chk(iss_slot[3] == 0, "R6 alu pair slot0", iss_slot[3], 0);
    chk(iss_slot[12] == 1, "R6 alu pair slot1", iss_slot[12], 1);

    // divider spacing and multiplier contention
    do_reset();
    p_n = 5;
    put(0, 2, 2, 1);
    put(1, 1, 4, 2);
    put(2, 1, 5, 2);
    put(3, 2, 6, 7);
    put(4, 0, 9, 8);
    go();
    wait_cyc(12);
    chk(iss_cyc[2] == 1, "R7 first divide", iss_cyc[2], 1);
    chk(iss_cyc[6] == 5, "R7 second divide at c+DIV_LAT", iss_cyc[6], 5);
    chk(iss_cyc[9] == 5, "R4 add passes stalled multiplies", iss_cyc[9], 5);
    chk(iss_cyc[4] == 6, "R6 first multiply", iss_cyc[4], 6);
    chk(iss_cyc[5] == 7, "R6 second multiply waits a cycle", iss_cyc[5], 7);

    // window fill, back-pressure, release and compaction (R1 R5)
    do_reset();
    hold[2] = 1;
    p_n = 10;
    put(0, 2, 2, 1);
    for (int r = 3; r <= 10; r++) put(r - 2, 0, r, 2);
    put(9, 0, 11, 1);
    go();
    wait_cyc(8);
    chk(in_ready == 1'b1, "R1 ready at seven entries", int'(in_ready), 1);
    wait_cyc(9);
    chk(in_ready == 1'b0, "R1 not ready when full", int'(in_ready), 0);
    wait_cyc(12);
    chk(in_ready == 1'b0, "R1 stays full", int'(in_ready), 0);
    chk(n_iss == 1, "R2 adds held by pending register", n_iss, 1);
    due[2] = 13;
    hold[2] = 0;
    wait_cyc(14);
    chk(in_ready == 1'b0, "R1 full during first drain cycle", int'(in_ready), 0);
    wait_cyc(15);
    chk(in_ready == 1'b1, "R1 ready after drain", int'(in_ready), 1);
    wait_cyc(22);
    chk(iss_cyc[3] == 14 && iss_slot[3] == 0, "R5 oldest in slot0", iss_cyc[3], 14);
    chk(iss_cyc[4] == 14 && iss_slot[4] == 1, "R5 next oldest in slot1", iss_cyc[4], 14);
    chk(iss_cyc[6] == 15, "R5 second pair", iss_cyc[6], 15);
    chk(iss_cyc[8] == 16, "R5 order kept over new entry", iss_cyc[8], 16);
    chk(iss_cyc[10] == 17, "R5 fourth pair", iss_cyc[10], 17);
    chk(iss_cyc[11] == 18, "R5 late entry last", iss_cyc[11], 18);

    // read-after-write on the scoreboard and write-after-read in the window
    do_reset();
    p_n = 4;
    put(0, 2, 3, 1);
    put(1, 0, 3, 4);
    put(2, 0, 4, 7);
    put(3, 0, 8, 9);
    go();
    wait_cyc(12);
    chk(iss_cyc[8] == 4, "R4 independent op issues early", iss_cyc[8], 4);
    chk(iss_cyc[3] == 6, "R2 issue the cycle after write-back", iss_cyc[3], 6);
    chk(iss_cyc[4] == 7, "R3 write-after-read waits for older reader", iss_cyc[4], 7);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule